// File: doc/BRIEF.md
# Serial-Peripheral Command Translator

This block sits between a host command channel and the transceiver of a slow serial peripheral bus. A host packet arrives as a byte array with a length. The block validates it, squeezes it into a compact bus request and waits for the transceiver to answer. It then packs the answer into a stored reply buffer and pulses a reply-pending strobe. A reserved leading byte pair marks an in-band packet that configures the bus's automatic polling instead. Such a packet produces no bus traffic and no strobe.

A configuration input says whether the peripheral bus exists at all. When it does not, every packet is quietly dropped. A transceiver that never answers is cut off after a fixed number of cycles, and the block then reports an empty reply. The block accepts one command at a time. `busy` stays high while a bus request is outstanding.

Top module: `perbus_cmd_xlate`

## Requirements
- R1: A packet with a length below 2 is dropped. No request, no reply strobe, no change to the reply buffer or the autopoll outputs.
- R2: While `bus_present` is 0, any packet is dropped. No request, no strobe, and the autopoll mask and enable stay as they were.
- R3: A packet whose byte 0 is 0x00 and byte 1 is 0x86 is an autopoll setting. It is acted on only when its length is exactly 4. Any other length drops it. An autopoll setting never issues a request or a strobe.
- R4: A valid autopoll setting with a nonzero mask {byte 2, byte 3} (byte 2 in bits 15:8) loads `apoll_mask` and sets `apoll_en`. A zero mask clears `apoll_en` and keeps the mask. After reset both outputs are 0.
- R5: A command packet is an error in any of these cases: its length is below 3, its length exceeds MAX_PKT, byte 2 exceeds length minus 3, or byte 2 exceeds 252. An error stores a 1-byte reply 0x00, with all other reply bytes zero and `rpl_size` = 1, and pulses the strobe in the cycle after the packet. No request is made.
- R6: A good command raises `bus_req_valid` in the cycle after the packet. `bus_req_len` is the length minus 2. The request bytes are byte 0 and then packet bytes 3 onward, and unused request bytes are zero. The request stays unchanged until the block gets an answer or times out.
- R7: When `bus_done` arrives with a reply length n > 0, the block stores the reply 0x01, n, then data bytes 0..n-1, with the remaining bytes zero and `rpl_size` = n+2. Lengths above MAX_RPL are clamped to MAX_RPL.
- R8: An answer of length 0 stores the 1-byte reply 0x00. A request with no `bus_done` for TIMEOUT cycles is ended the same way.
- R9: `rpl_event` is a single-cycle pulse in the cycle after an error packet, an answer or a timeout. It is 0 after reset.
- R10: A packet offered while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Packet offered this cycle |
| cmd_len | input | LW | Packet length in bytes |
| cmd_data | input | MAX_PKT*8 | Packet bytes, byte k in bits 8k+7:8k |
| bus_present | input | 1 | Peripheral bus exists |
| busy | output | 1 | Bus request outstanding |
| bus_req_valid | output | 1 | Request to the transceiver |
| bus_req_len | output | LW | Request length |
| bus_req_data | output | MAX_PKT*8 | Request bytes, byte k in bits 8k+7:8k |
| bus_done | input | 1 | Transceiver answer valid |
| bus_rsp_len | input | RLW | Answer length |
| bus_rsp_data | input | MAX_RPL*8 | Answer bytes |
| apoll_mask | output | 16 | Autopoll device mask |
| apoll_en | output | 1 | Autopoll enabled |
| rpl_size | output | SW | Stored reply size |
| rpl_data | output | (MAX_RPL+2)*8 | Stored reply bytes |
| rpl_event | output | 1 | Reply-pending strobe |

## Verification
The hardest cases to reach are a second packet arriving while a request is still outstanding and the timeout expiring. Neither happens if the transceiver answers at once. The bench stalls its transceiver model and injects an error-class packet mid-request. It then checks that no strobe appears and that the request bytes hold. In a separate case the bench withholds `bus_done` for the whole window and checks the request one cycle before and one cycle after expiry. The length checks come from a sweep over every length up to beyond MAX_PKT, crossed with several embedded-length values.

// File: rtl/perbus_cmd_xlate.sv
`timescale 1ns/1ps
module perbus_cmd_xlate #(
  parameter int MAX_PKT = 8,
  parameter int MAX_RPL = 8,
  parameter int TIMEOUT = 32,
  parameter int LW      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [LW-1:0]              cmd_len,
  input  logic [MAX_PKT*8-1:0]       cmd_data,
  input  logic                       bus_present,
  output logic                       busy,
  output logic                       bus_req_valid,
  output logic [LW-1:0]              bus_req_len,
  output logic [MAX_PKT*8-1:0]       bus_req_data,
  input  logic                       bus_done,
  input  logic [$clog2(MAX_RPL+1)-1:0] bus_rsp_len,
  input  logic [MAX_RPL*8-1:0]       bus_rsp_data,
  output logic [15:0]                apoll_mask,
  output logic                       apoll_en,
  output logic [$clog2(MAX_RPL+3)-1:0] rpl_size,
  output logic [(MAX_RPL+2)*8-1:0]   rpl_data,
  output logic                       rpl_event
);
  localparam int RLW = $clog2(MAX_RPL+1);
  localparam int SW  = $clog2(MAX_RPL+3);
  localparam int TW  = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam int RB  = MAX_RPL + 2;

  logic          waiting;
  logic [TW-1:0] tmr;

  wire [7:0] b0 = cmd_data[7:0];
  wire [7:0] b1 = cmd_data[15:8];
  wire [7:0] b2 = cmd_data[23:16];
  wire [15:0] mask_in = {cmd_data[23:16], cmd_data[31:24]};

  wire accept  = cmd_valid && !waiting && bus_present && (int'(cmd_len) >= 2);
  wire is_ap   = (b0 == 8'h00) && (b1 == 8'h86);
  wire len_bad = (int'(cmd_len) < 3) || (int'(cmd_len) > MAX_PKT) ||
                 (int'(b2) + 3 > int'(cmd_len)) || (int'(b2) > 252);
  wire go_ap   = accept && is_ap && (int'(cmd_len) == 4);
  wire go_err  = accept && !is_ap && len_bad;
  wire go_bus  = accept && !is_ap && !len_bad;
  wire tm_hit  = waiting && !bus_done && (tmr == TW'(TIMEOUT-1));

  assign busy          = waiting;
  assign bus_req_valid = waiting;

  logic [MAX_PKT*8-1:0] req_nxt;
  assign req_nxt[7:0] = b0;
  for (genvar i = 1; i < MAX_PKT; i++) begin : g_req
    if (i + 2 < MAX_PKT) begin : g_src
      assign req_nxt[8*i +: 8] = (int'(cmd_len) > i + 2) ? cmd_data[8*(i+2) +: 8] : 8'h00;
    end else begin : g_pad
      assign req_nxt[8*i +: 8] = 8'h00;
    end
  end

  wire [RLW-1:0] n_cl = (int'(bus_rsp_len) > MAX_RPL) ? RLW'(MAX_RPL) : bus_rsp_len;
  wire           has_n = (n_cl != '0);
  logic [RB*8-1:0] rpl_nxt;
  assign rpl_nxt[7:0]  = has_n ? 8'h01 : 8'h00;
  assign rpl_nxt[15:8] = has_n ? 8'(n_cl) : 8'h00;
  for (genvar k = 0; k < MAX_RPL; k++) begin : g_rpl
    assign rpl_nxt[8*(k+2) +: 8] = (int'(n_cl) > k) ? bus_rsp_data[8*k +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting      <= 1'b0;
      tmr          <= '0;
      bus_req_len  <= '0;
      bus_req_data <= '0;
      apoll_mask   <= '0;
      apoll_en     <= 1'b0;
      rpl_size     <= '0;
      rpl_data     <= '0;
      rpl_event    <= 1'b0;
    end else begin
      rpl_event <= 1'b0;
      if (go_ap) begin
        if (mask_in != 16'h0) begin
          apoll_mask <= mask_in;
          apoll_en   <= 1'b1;
        end else begin
          apoll_en   <= 1'b0;
        end
      end
      if (go_err) begin
        rpl_data  <= '0;
        rpl_size  <= SW'(1);
        rpl_event <= 1'b1;
      end
      if (go_bus) begin
        waiting      <= 1'b1;
        tmr          <= '0;
        bus_req_len  <= cmd_len - LW'(2);
        bus_req_data <= req_nxt;
      end
      if (waiting) begin
        if (bus_done) begin
          rpl_data  <= rpl_nxt;
          rpl_size  <= has_n ? SW'(n_cl) + SW'(2) : SW'(1);
          rpl_event <= 1'b1;
          waiting   <= 1'b0;
        end else if (tm_hit) begin
          rpl_data  <= '0;
          rpl_size  <= SW'(1);
          rpl_event <= 1'b1;
          waiting   <= 1'b0;
        end else begin
          tmr <= tmr + TW'(1);
        end
      end
    end
  end

  AST_SHORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && int'(cmd_len) < 2 |=> !rpl_event && !bus_req_valid); // R1
  AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && !bus_present |=> !rpl_event && !bus_req_valid && $stable(apoll_en) && $stable(apoll_mask)); // R2
  AST_AP_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && is_ap |=> !rpl_event && !bus_req_valid); // R3
  AST_ZERO_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !busy && bus_present && is_ap && int'(cmd_len) == 4 && mask_in == 16'h0 |=> !apoll_en && $stable(apoll_mask)); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_done && tmr != TW'(TIMEOUT-1) |=> bus_req_valid && $stable(bus_req_data) && $stable(bus_req_len)); // R6
  AST_REPLY_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_event |-> (rpl_data[7:0] == 8'h00 && int'(rpl_size) == 1) ||
                  (rpl_data[7:0] == 8'h01 && int'(rpl_size) == int'(rpl_data[15:8]) + 2)); // R7
  AST_EVENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_event |=> !rpl_event); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && cmd_valid && !bus_done && tmr != TW'(TIMEOUT-1) |=> !rpl_event && bus_req_valid); // R10
endmodule

// File: tb/perbus_cmd_xlate_tb_top.sv
`timescale 1ns/1ps
module perbus_cmd_xlate_tb_top;
  localparam int MAX_PKT = 8;
  localparam int MAX_RPL = 8;
  localparam int TIMEOUT = 32;
  localparam int LW  = 8;
  localparam int RLW = $clog2(MAX_RPL+1);
  localparam int SW  = $clog2(MAX_RPL+3);
  localparam int RB  = MAX_RPL + 2;

  logic clk = 0, rst_n = 0, cmd_valid = 0, bus_present = 1, bus_done = 0;
  logic [LW-1:0] cmd_len = '0;
  logic [MAX_PKT*8-1:0] cmd_data = '0;
  logic [RLW-1:0] bus_rsp_len = '0;
  logic [MAX_RPL*8-1:0] bus_rsp_data;
  logic busy, bus_req_valid, apoll_en, rpl_event;
  logic [LW-1:0] bus_req_len;
  logic [MAX_PKT*8-1:0] bus_req_data;
  logic [15:0] apoll_mask;
  logic [SW-1:0] rpl_size;
  logic [RB*8-1:0] rpl_data;

  int tests = 0, fails = 0;
  logic [7:0] pkt [MAX_PKT+4];

  always #2 clk = ~clk;

  perbus_cmd_xlate #(.MAX_PKT(MAX_PKT), .MAX_RPL(MAX_RPL), .TIMEOUT(TIMEOUT), .LW(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .bus_present(bus_present), .busy(busy), .bus_req_valid(bus_req_valid),
    .bus_req_len(bus_req_len), .bus_req_data(bus_req_data), .bus_done(bus_done),
    .bus_rsp_len(bus_rsp_len), .bus_rsp_data(bus_rsp_data), .apoll_mask(apoll_mask),
    .apoll_en(apoll_en), .rpl_size(rpl_size), .rpl_data(rpl_data), .rpl_event(rpl_event));

  task automatic check(string rq, string what, logic [127:0] act, logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [RB*8-1:0] exp_rpl(int n);
    logic [RB*8-1:0] v = '0;
    if (n > 0) begin
      v[7:0] = 8'h01; v[15:8] = 8'(n);
      for (int k = 0; k < n; k++) v[8*(k+2) +: 8] = 8'hA0 + 8'(k);
    end
    return v;
  endfunction

  function automatic logic [MAX_PKT*8-1:0] exp_req(int len);
    logic [MAX_PKT*8-1:0] v = '0;
    v[7:0] = pkt[0];
    for (int i = 1; i <= len - 3; i++) v[8*i +: 8] = pkt[i+2];
    return v;
  endfunction

  // 0 drop, 1 autopoll, 2 error, 3 bus
  function automatic int classify(int len, bit present);
    if (len < 2 || !present) return 0;
    if (pkt[0] == 8'h00 && pkt[1] == 8'h86) return (len == 4) ? 1 : 0;
    if (len < 3 || len > MAX_PKT || int'(pkt[2]) > len - 3 || int'(pkt[2]) > 252) return 2;
    return 3;
  endfunction

  task automatic send(int len, bit present);
    cmd_valid = 1; cmd_len = LW'(len); bus_present = present;
    for (int i = 0; i < MAX_PKT; i++) cmd_data[8*i +: 8] = pkt[i];
    @(negedge clk);
    cmd_valid = 0; bus_present = 1;
  endtask

  task automatic run(int len, bit present, int n);
    int cls = classify(len, present);
    logic [15:0] pm = apoll_mask;
    logic pe = apoll_en;
    logic [RB*8-1:0] pr = rpl_data;
    send(len, present);
    case (cls)
      0: begin
        check(present ? "R1/R3" : "R2", "drop event", rpl_event, 0);
        check(present ? "R1/R3" : "R2", "drop req", bus_req_valid, 0);
        check(present ? "R1/R3" : "R2", "drop autopoll", {pe, pm}, {apoll_en, apoll_mask});
        check(present ? "R1/R3" : "R2", "drop reply", rpl_data, pr);
        @(negedge clk);
        check(present ? "R1/R3" : "R2", "drop event late", rpl_event, 0);
      end
      1: begin
        check("R3", "ap event", {rpl_event, bus_req_valid}, 0);
        if ({pkt[2], pkt[3]} != 16'h0) check("R4", "ap load", {apoll_en, apoll_mask}, {1'b1, pkt[2], pkt[3]});
        else check("R4", "ap off", {apoll_en, apoll_mask}, {1'b0, pm});
      end
      2: begin
        check("R5", "err event", rpl_event, 1);
        check("R5", "err size", rpl_size, 1);
        check("R5", "err data", rpl_data, 0);
        check("R5", "err req", bus_req_valid, 0);
        @(negedge clk);
        check("R9", "err pulse", rpl_event, 0);
      end
      default: begin
        check("R6", "req valid", bus_req_valid, 1);
        check("R6", "req len", bus_req_len, LW'(len - 2));
        check("R6", "req data", bus_req_data, exp_req(len));
        bus_rsp_len = RLW'(n); bus_done = 1;
        @(negedge clk);
        bus_done = 0;
        check(n > 0 ? "R7" : "R8", "rsp event", rpl_event, 1);
        check(n > 0 ? "R7" : "R8", "rsp size", rpl_size, (n > 0) ? n + 2 : 1);
        check(n > 0 ? "R7" : "R8", "rsp data", rpl_data, exp_rpl(n));
        check("R6", "req drop", bus_req_valid, 0);
        @(negedge clk);
        check("R9", "rsp pulse", rpl_event, 0);
      end
    endcase
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    automatic int b2v [6] = '{0, 1, 2, 3, 5, 250};
    for (int k = 0; k < MAX_RPL; k++) bus_rsp_data[8*k +: 8] = 8'hA0 + 8'(k);
    for (int i = 0; i < MAX_PKT + 4; i++) pkt[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R4", "reset apoll", {apoll_en, apoll_mask}, 0);
    check("R9", "reset event", {rpl_event, busy, bus_req_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int len = 0; len <= MAX_PKT + 2; len++)
      for (int s = 0; s < 6; s++) begin
        pkt[0] = 8'h40 + 8'(len); pkt[1] = 8'h20 + 8'(s); pkt[2] = 8'(b2v[s]);
        for (int i = 3; i < MAX_PKT + 4; i++) pkt[i] = 8'(16 * i + len);
        run(len, 1, (len + s) % (MAX_RPL + 1));
      end

    for (int len = 2; len <= 6; len++) begin
      pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h01;
      run(len, 0, 2);
    end

    pkt[0] = 8'h00; pkt[1] = 8'h86; pkt[2] = 8'h12; pkt[3] = 8'h34;
    run(4, 1, 0);
    run(5, 1, 0);
    run(3, 1, 0);
    pkt[2] = 8'hAB; pkt[3] = 8'hCD;
    run(4, 0, 0);
    pkt[2] = 8'h00; pkt[3] = 8'h00;
    run(4, 1, 0);
    check("R4", "mask kept", apoll_mask, 16'h1234);
    pkt[2] = 8'h80; pkt[3] = 8'h01;
    run(4, 1, 0);
    pkt[0] = 8'h00; pkt[1] = 8'h85; pkt[2] = 8'h01; pkt[3] = 8'h77;
    run(4, 1, 1);

    // R8 timeout
    pkt[0] = 8'h33; pkt[1] = 8'h44; pkt[2] = 8'h01; pkt[3] = 8'h55;
    send(4, 1);
    check("R6", "to req", bus_req_valid, 1);
    repeat (TIMEOUT - 1) @(negedge clk);
    check("R8", "to still waiting", {bus_req_valid, rpl_event}, 2'b10);
    @(negedge clk);
    check("R8", "to event", {bus_req_valid, rpl_event}, 2'b01);
    check("R8", "to reply", {rpl_size, rpl_data}, {SW'(1), {RB*8{1'b0}}});
    @(negedge clk);

    // R10 packet while busy
    pkt[0] = 8'h5A; pkt[1] = 8'h00; pkt[2] = 8'h02; pkt[3] = 8'hC1; pkt[4] = 8'hC2;
    send(5, 1);
    check("R10", "busy", busy, 1);
    pkt[0] = 8'h99; pkt[2] = 8'h09;
    send(3, 1);
    check("R10", "no event", rpl_event, 0);
    check("R10", "req held", {bus_req_len, bus_req_data}, {LW'(3), 40'h0, 8'hC2, 8'hC1, 8'h5A});
    bus_rsp_len = RLW'(3); bus_done = 1;
    @(negedge clk);
    bus_done = 0;
    check("R7", "after busy reply", {rpl_size, rpl_data}, {SW'(5), exp_rpl(3)});
    @(negedge clk);

    // R7 clamp above MAX_RPL
    pkt[0] = 8'h61; pkt[2] = 8'h00;
    send(3, 1);
    bus_rsp_len = RLW'(MAX_RPL + 3); bus_done = 1;
    @(negedge clk);
    bus_done = 0;
    check("R7", "clamp", {rpl_size, rpl_data}, {SW'(MAX_RPL + 2), exp_rpl(MAX_RPL)});
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule